// File: doc/BRIEF.md
# Motor Lock Fault Supervisor

This block sits between a set of six fault detectors and the output stage of a motor drive. Five detectors report a locked or stalled rotor and the sixth reports that no motor is attached. Each source raises a one-cycle pulse. The block keeps a sticky record of every source that has fired. It also checks each pulse against a per-source enable mask. When an enabled source fires, the block takes the drive off the motor.

Every shutdown follows the same path. The block leaves RUN and enters AVS. In AVS it disables the output stage and asks an external surge-suppression step to run through the `avs_req`/`avs_done` handshake. Once that step reports done, the block moves to OFF_WAIT and holds the drive off for a programmable number of cycles. It then passes through RESTART, where it emits a one-cycle restart request and clears the record. From RESTART it returns to RUN with the outputs enabled.

The transitions are fixed. RUN goes to AVS on an enabled fault. AVS goes to OFF_WAIT when the suppression step is done and the off time is non-zero. AVS goes straight to RESTART when it is done and the off time is zero. OFF_WAIT goes to RESTART when its counter expires. RESTART always goes to RUN.

Top module: `lock_fault_supervisor`

## Requirements
- R1: After reset the block is in RUN: `drv_oe`=1, `avs_req`=0, `restart_req`=0 and `fault_status`=0.
- R2: Bit n of `fault_status` sets one cycle after `fault_pulse[n]` is high in RUN, AVS or OFF_WAIT, whatever the value of `fault_en[n]`. The bit stays set until a restart.
- R3: In RUN, a pulse on any source n with `fault_en[n]`=1 makes `drv_oe` 0 and `avs_req` 1 on the next cycle. A pulse only on sources whose enable bit is 0 leaves `drv_oe` at 1.
- R4: `drv_oe` only falls in the same cycle that `avs_req` rises. `avs_req` then stays high, with `drv_oe` low, until `avs_done` is sampled high.
- R5: The block samples `off_cycles`=N in the cycle where it sees `avs_done` high in AVS. `restart_req` goes high exactly N+1 cycles after that cycle, and `drv_oe` stays 0 throughout.
- R6: If N=0, `restart_req` goes high in the cycle right after `avs_done` is seen.
- R7: Fault pulses during AVS or OFF_WAIT set status bits. They do not start a new AVS step and they do not change the off time.
- R8: `restart_req` is high for exactly one cycle. On the next cycle `fault_status` is 0, `drv_oe` is 1 and `avs_req` is 0.
- R9: Fault pulses in the cycle where `restart_req` is high are dropped. They set no status bit and cause no shutdown.
- R10: `avs_done` has no effect outside AVS. In RUN it leaves `drv_oe`=1, `avs_req`=0 and `restart_req`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_pulse | input | 6 | One pulse line per fault source; bit n is source n |
| fault_en | input | 6 | Enable mask; bit n lets source n shut the drive down |
| off_cycles | input | 16 | Off time in cycles, sampled when the suppression step completes |
| avs_done | input | 1 | Surge-suppression step complete |
| drv_oe | output | 1 | Output-stage enable; 0 puts the drivers in high impedance |
| avs_req | output | 1 | Request for the surge-suppression step |
| restart_req | output | 1 | One-cycle motor restart request |
| fault_status | output | 6 | Sticky record of the sources that fired; bit n is source n |

## Verification
Two cases are hard to reach from the ports. The first is a fault that lands while the block is already shut down. The second is a fault that lands in the single cycle where the restart request is high. The bench reaches both by driving the full recovery handshake itself. It counts cycles after `avs_done` so that it can inject all six pulses at a known point inside OFF_WAIT, and it injects them again in the cycle where it sees `restart_req`. The bench sweeps every enable mask against every source, and it sweeps the off time and the length of the suppression step. This exposes the exact cycle counts N+1 and the N=0 shortcut.

// File: rtl/lfs_pkg.sv
package lfs_pkg;

    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_AVS      = 2'd1,
        ST_OFF_WAIT = 2'd2,
        ST_RESTART  = 2'd3
    } lfs_state_e;

endpackage

// File: rtl/lfs_status_reg.sv
module lfs_status_reg #(
    parameter int NSRC = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_vec,
    input  logic            clr,
    output logic [NSRC-1:0] status
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= '0;
        end else if (clr) begin
            status <= '0;
        end else begin
            status <= status | set_vec;
        end
    end

endmodule

// File: rtl/lfs_off_timer.sv
module lfs_off_timer #(
    parameter int OFF_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [OFF_W-1:0] load_val,
    input  logic             run,
    output logic             expired
);

    logic [OFF_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val - OFF_W'(1);
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - OFF_W'(1);
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/lfs_fsm.sv
module lfs_fsm
    import lfs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trip,
    input  logic       avs_done,
    input  logic       off_zero,
    input  logic       wait_done,
    output lfs_state_e state,
    output logic       timer_load,
    output logic       timer_run,
    output logic       drv_oe,
    output logic       avs_req,
    output logic       restart_req,
    output logic       status_clr
);

    lfs_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RUN;
        end else begin
            state <= state_d;
        end
    end

    always_comb begin
        state_d = state;
        unique case (state)
            ST_RUN:      if (trip) state_d = ST_AVS;
            ST_AVS:      if (avs_done) state_d = off_zero ? ST_RESTART : ST_OFF_WAIT;
            ST_OFF_WAIT: if (wait_done) state_d = ST_RESTART;
            ST_RESTART:  state_d = ST_RUN;
        endcase
    end

    always_comb begin
        drv_oe      = 1'b0;
        avs_req     = 1'b0;
        restart_req = 1'b0;
        status_clr  = 1'b0;
        timer_load  = 1'b0;
        timer_run   = 1'b0;
        unique case (state)
            ST_RUN:      drv_oe = 1'b1;
            ST_AVS: begin
                avs_req    = 1'b1;
                timer_load = avs_done;
            end
            ST_OFF_WAIT: timer_run = 1'b1;
            ST_RESTART: begin
                restart_req = 1'b1;
                status_clr  = 1'b1;
            end
        endcase
    end

    // R6
    zero_off_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_AVS && avs_done && off_zero) |=> (state == ST_RESTART));

endmodule

// File: rtl/lock_fault_supervisor.sv
module lock_fault_supervisor
    import lfs_pkg::*;
#(
    parameter int NSRC  = 6,
    parameter int OFF_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  fault_pulse,
    input  logic [NSRC-1:0]  fault_en,
    input  logic [OFF_W-1:0] off_cycles,
    input  logic             avs_done,
    output logic             drv_oe,
    output logic             avs_req,
    output logic             restart_req,
    output logic [NSRC-1:0]  fault_status
);

    lfs_state_e      state;
    logic            trip;
    logic            timer_load;
    logic            timer_run;
    logic            wait_done;
    logic            status_clr;
    logic [NSRC-1:0] set_vec;

    assign trip    = |(fault_pulse & fault_en);
    assign set_vec = status_clr ? '0 : fault_pulse;

    lfs_status_reg #(.NSRC(NSRC)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr     (status_clr),
        .status  (fault_status)
    );

    lfs_off_timer #(.OFF_W(OFF_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (off_cycles),
        .run      (timer_run),
        .expired  (wait_done)
    );

    lfs_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .trip        (trip),
        .avs_done    (avs_done),
        .off_zero    (off_cycles == '0),
        .wait_done   (wait_done),
        .state       (state),
        .timer_load  (timer_load),
        .timer_run   (timer_run),
        .drv_oe      (drv_oe),
        .avs_req     (avs_req),
        .restart_req (restart_req),
        .status_clr  (status_clr)
    );

    // R2
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|fault_pulse && !restart_req) |=>
            ((fault_status & $past(fault_pulse)) == $past(fault_pulse)));

    // R3
    trip_shutdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_oe && |(fault_pulse & fault_en)) |=> (!drv_oe && avs_req));

    // R4
    oe_fall_avs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv_oe) |-> avs_req);

    // R4
    avs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (avs_req && !avs_done) |=> (avs_req && !drv_oe));

    // R8
    restart_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req |=> (!restart_req && drv_oe && fault_status == '0));

endmodule

// File: tb/lock_fault_supervisor_tb.sv
module lock_fault_supervisor_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  fault_pulse = '0;
    logic [5:0]  fault_en = '0;
    logic [15:0] off_cycles = '0;
    logic        avs_done = 1'b0;
    logic        drv_oe;
    logic        avs_req;
    logic        restart_req;
    logic [5:0]  fault_status;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    lock_fault_supervisor u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .fault_pulse  (fault_pulse),
        .fault_en     (fault_en),
        .off_cycles   (off_cycles),
        .avs_done     (avs_done),
        .drv_oe       (drv_oe),
        .avs_req      (avs_req),
        .restart_req  (restart_req),
        .fault_status (fault_status)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Completes a shutdown already in AVS: holds avs_done low for hold cycles,
    // then completes with off time n, optionally injecting faults mid-wait (R7)
    // and during the restart cycle (R9).
    task automatic recover(input int n, input int hold, input bit inj_wait, input bit inj_rst);
        int cnt = 0;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk(avs_req && !drv_oe, "R4 avs held", {avs_req, drv_oe}, 2'b10);
        end
        off_cycles = 16'(n);
        avs_done = 1'b1;
        while (cnt < 70000) begin
            @(negedge clk);
            avs_done = 1'b0;
            fault_pulse = '0;
            cnt++;
            if (restart_req) break;
            chk(!drv_oe, "R5 drive off in wait", drv_oe, 0);
            chk(!avs_req, "R7 no second avs", avs_req, 0);
            if (inj_wait && cnt == 1 && n >= 3) begin
                fault_en = 6'h3f;
                fault_pulse = 6'h3f;
            end
            if (inj_wait && cnt == 2 && n >= 3)
                chk(fault_status == 6'h3f, "R7 status set during wait", fault_status, 6'h3f);
        end
        chk(cnt == n + 1, (n == 0) ? "R6 zero off time" : "R5 off time", cnt, n + 1);
        if (inj_rst) begin
            fault_en = 6'h3f;
            fault_pulse = 6'h3f;
        end
        @(negedge clk);
        fault_pulse = '0;
        chk(!restart_req, "R8 restart one cycle", restart_req, 0);
        chk(drv_oe && !avs_req, inj_rst ? "R9 restart-cycle fault dropped" : "R8 drive back on",
            {drv_oe, avs_req}, 2'b10);
        chk(fault_status == '0, inj_rst ? "R9 status stays clear" : "R8 status cleared",
            fault_status, 0);
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(drv_oe && !avs_req && !restart_req && fault_status == 0, "R1 reset state",
            {drv_oe, avs_req, restart_req, fault_status}, 9'h100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(drv_oe && !avs_req && !restart_req && fault_status == 0, "R1 after release",
            {drv_oe, avs_req, restart_req, fault_status}, 9'h100);

        // R10: avs_done outside AVS is ignored
        avs_done = 1'b1;
        @(negedge clk);
        avs_done = 1'b0;
        chk(drv_oe && !avs_req && !restart_req, "R10 stray avs_done",
            {drv_oe, avs_req, restart_req}, 3'b100);
        @(negedge clk);
        chk(drv_oe && !restart_req, "R10 stray avs_done later", {drv_oe, restart_req}, 2'b10);

        // R2/R3: every mask against every source
        for (int m = 0; m < 64; m++) begin
            for (int s = 0; s < 6; s++) begin
                fault_en = 6'(m);
                fault_pulse = 6'(1 << s);
                @(negedge clk);
                fault_pulse = '0;
                chk(fault_status == 6'(1 << s), "R2 status bit", fault_status, 1 << s);
                if (m[s]) begin
                    chk(!drv_oe && avs_req, "R3 enabled trip", {drv_oe, avs_req}, 2'b01);
                    recover((m + s) % 4, s % 3, 1'b0, 1'b0);
                end else begin
                    chk(drv_oe && !avs_req, "R3 disabled source no trip", {drv_oe, avs_req}, 2'b10);
                    @(negedge clk);
                    chk(fault_status == 6'(1 << s) && drv_oe, "R2 sticky",
                        fault_status, 1 << s);
                    fault_en = 6'h3f;
                    fault_pulse = 6'(1 << s);
                    @(negedge clk);
                    fault_pulse = '0;
                    chk(!drv_oe && avs_req, "R3 enabled trip", {drv_oe, avs_req}, 2'b01);
                    recover(0, 0, 1'b0, 1'b0);
                end
            end
        end

        // R5/R7: off time sweep with faults during wait; R9 at restart
        for (int n = 0; n < 40; n++) begin
            fault_en = 6'h01;
            fault_pulse = 6'h01;
            @(negedge clk);
            fault_pulse = 6'h3f;
            fault_en = 6'h3f;
            @(negedge clk);
            fault_pulse = '0;
            chk(fault_status == 6'h3f, "R7 fault during avs", fault_status, 6'h3f);
            recover(n, n % 5, 1'b1, n[0]);
        end

        // R5: large off time
        fault_en = 6'h20;
        fault_pulse = 6'h20;
        @(negedge clk);
        fault_pulse = '0;
        recover(5000, 2, 1'b1, 1'b1);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule